// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address by reading a four-level radix translation table from memory. A caller hands it one request at a time: the virtual address, whether the access is a write, and whether it comes from user or supervisor mode. The block takes the top-level table location from a root-pointer input, then descends one level per memory read until it reaches the leaf entry.

The access checks are part of the walk. A walk can end with a translation or with a fault. A fault is one of three kinds: an absent entry, a user access to a supervisor-only page, or a write to a read-only page. An absent-entry fault also reports the level where the walk stopped. The leaf offset passes through untouched. Each 64-bit entry carries a present flag (bit 0), a writable flag (bit 1), a user flag (bit 2), and the next table or page frame number in bits 51:12.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and right after it, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_rd_valid_o` are 0.
- R2: A walk issues its reads from level 3 down to level 0. The entry address at level L is {table frame, VA[12+9L+8 : 12+9L], 3'b000}. The level-3 table frame is the root frame, and each lower frame is entry bits 51:12 of the level above. A walk with no fault makes exactly four reads.
- R3: A walk with no fault returns fault code 0 and level 0. It returns the physical address {leaf bits 51:12, VA[11:0]} and perm = leaf bits {2,1,0} as {user, writable, present}.
- R4: An entry with bit 0 clear at level L ends the walk after 4-L reads. It returns fault code 1, level L, address 0 and perm 0.
- R5: A user-mode access (`req_user_i`=1) whose leaf has bit 2 clear returns fault code 2 at level 0. A supervisor access to the same leaf translates normally.
- R6: A write (`req_write_i`=1) whose leaf has bit 1 clear returns fault code 3 at level 0. When both checks fail, fault code 2 wins over fault code 3.
- R7: Only one walk is in flight. `req_ready_o` stays 0 from the acceptance of a request until its response is taken. The response holds every output steady while `rsp_ready_i` is 0.
- R8: The root frame is sampled when the request is accepted. Later changes to `root_ppn_i` do not affect that walk.
- R9: A pending memory read keeps `mem_rd_valid_o` high and `mem_rd_addr_o` unchanged until `mem_rd_ready_i` is seen.
- R10: The writable and user flags of non-leaf entries have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_ppn_i | input | 40 | Frame number of the level-3 table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_va_i | input | 48 | Virtual address to translate |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_user_i | input | 1 | 1 = user mode, 0 = supervisor |
| mem_rd_valid_o | output | 1 | Entry read request valid |
| mem_rd_ready_i | input | 1 | Memory accepts the read |
| mem_rd_addr_o | output | 52 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid (one pulse per read) |
| mem_rsp_data_i | input | 64 | Entry returned by memory |
| rsp_valid_o | output | 1 | Walk result valid |
| rsp_ready_i | input | 1 | Caller takes the result |
| rsp_pa_o | output | 52 | Physical address (0 on fault) |
| rsp_perm_o | output | 3 | Leaf {user, writable, present} (0 on fault) |
| rsp_fault_o | output | 2 | 0 none, 1 absent, 2 privilege, 3 write-protect |
| rsp_level_o | output | 2 | Level at which the walk ended |

## Verification
The checks assume that memory gives exactly one single-cycle `mem_rsp_valid_i` pulse for each accepted read, and only while the walker is waiting for it. They also assume there is never more than one read outstanding. The bench memory model follows this rule: it answers one cycle after each handshake it records and never pulses otherwise. It stalls `mem_rd_ready_i` at random and sometimes holds off `rsp_ready_i`. Each walk uses freshly allocated tables, so the bench can compute the expected address list and result from its own table image.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned PTW_LEVELS = 4;
    localparam int unsigned PTW_IDX_W  = 9;
    localparam int unsigned PTW_OFF_W  = 12;
    localparam int unsigned PTW_PA_W   = 52;
    localparam int unsigned PTW_PTE_W  = 64;

    // flag positions inside one table entry
    localparam int unsigned PTE_PRES_BIT = 0;
    localparam int unsigned PTE_WR_BIT   = 1;
    localparam int unsigned PTE_USR_BIT  = 2;
    localparam int unsigned PTE_FLAG_W   = 3;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PRIV   = 2'd2,
        FLT_RDONLY = 2'd3
    } ptw_fault_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_REQ  = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_RESP    = 2'd3
    } ptw_state_e;

endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
    parameter int unsigned LEVELS = 4,
    parameter int unsigned IDX_W  = 9,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned PA_W   = 52,
    parameter int unsigned PTE_W  = 64,
    localparam int unsigned LVL_W  = $clog2(LEVELS),
    localparam int unsigned PPN_W  = PA_W - OFF_W,
    localparam int unsigned ENT_SH = $clog2(PTE_W / 8)
) (
    input  logic [LEVELS*IDX_W-1:0] va_idx_i,
    input  logic [LVL_W-1:0]        level_i,
    input  logic [PPN_W-1:0]        table_ppn_i,
    output logic [PA_W-1:0]         entry_addr_o
);

    logic [IDX_W-1:0] idx_per_lvl [LEVELS];

    // one index slice per level, level 0 in the lowest bits
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_per_lvl[g] = va_idx_i[g*IDX_W +: IDX_W];
    end

    logic [IDX_W-1:0] idx_sel;
    logic [OFF_W-1:0] byte_off;

    assign idx_sel      = idx_per_lvl[level_i];
    assign byte_off     = OFF_W'(idx_sel) << ENT_SH;
    assign entry_addr_o = {table_ppn_i, byte_off};

endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int unsigned PTE_W = 64,
    parameter int unsigned PA_W  = 52,
    parameter int unsigned OFF_W = 12,
    localparam int unsigned PPN_W = PA_W - OFF_W
) (
    input  logic [PTE_W-1:0]      pte_i,
    input  logic                  is_leaf_i,
    input  logic                  write_i,
    input  logic                  user_i,
    output logic                  present_o,
    output logic [PPN_W-1:0]      ppn_o,
    output logic [PTE_FLAG_W-1:0] perm_o,
    output ptw_fault_e            fault_o
);

    logic pres, wr_ok, usr_ok;

    assign pres      = pte_i[PTE_PRES_BIT];
    assign wr_ok     = pte_i[PTE_WR_BIT];
    assign usr_ok    = pte_i[PTE_USR_BIT];
    assign present_o = pres;
    assign ppn_o     = pte_i[OFF_W +: PPN_W];
    assign perm_o    = {usr_ok, wr_ok, pres};

    // privilege is tested before write protection
    always_comb begin
        if (!pres)
            fault_o = FLT_ABSENT;
        else if (is_leaf_i && user_i && !usr_ok)
            fault_o = FLT_PRIV;
        else if (is_leaf_i && write_i && !wr_ok)
            fault_o = FLT_RDONLY;
        else
            fault_o = FLT_NONE;
    end

    logic unused_pte_bits;
    assign unused_pte_bits = ^{pte_i[PTE_W-1:PA_W], pte_i[OFF_W-1:PTE_FLAG_W]};

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int unsigned LEVELS = PTW_LEVELS,
    parameter int unsigned IDX_W  = PTW_IDX_W,
    parameter int unsigned OFF_W  = PTW_OFF_W,
    parameter int unsigned PA_W   = PTW_PA_W,
    parameter int unsigned PTE_W  = PTW_PTE_W,
    localparam int unsigned LVL_W = $clog2(LEVELS),
    localparam int unsigned VA_W  = OFF_W + LEVELS*IDX_W,
    localparam int unsigned PPN_W = PA_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PPN_W-1:0]      root_ppn_i,
    input  logic                  req_valid_i,
    output logic                  req_ready_o,
    input  logic [VA_W-1:0]       req_va_i,
    input  logic                  req_write_i,
    input  logic                  req_user_i,
    output logic                  mem_rd_valid_o,
    input  logic                  mem_rd_ready_i,
    output logic [PA_W-1:0]       mem_rd_addr_o,
    input  logic                  mem_rsp_valid_i,
    input  logic [PTE_W-1:0]      mem_rsp_data_i,
    output logic                  rsp_valid_o,
    input  logic                  rsp_ready_i,
    output logic [PA_W-1:0]       rsp_pa_o,
    output logic [PTE_FLAG_W-1:0] rsp_perm_o,
    output logic [1:0]            rsp_fault_o,
    output logic [LVL_W-1:0]      rsp_level_o
);

    typedef struct packed {
        ptw_state_e            state;
        logic [LVL_W-1:0]      level;
        logic [VA_W-1:0]       va;
        logic                  wr;
        logic                  usr;
        logic [PPN_W-1:0]      tbl;
        logic [PA_W-1:0]       pa;
        logic [PTE_FLAG_W-1:0] perm;
        ptw_fault_e            fault;
        logic [LVL_W-1:0]      flevel;
    } walk_s;

    walk_s s_d, s_q;

    logic [PA_W-1:0]       entry_addr;
    logic                  ent_present;
    logic [PPN_W-1:0]      ent_ppn;
    logic [PTE_FLAG_W-1:0] ent_perm;
    ptw_fault_e            ent_fault;
    logic                  at_leaf;

    assign at_leaf = (s_q.level == '0);

    ptw_idx_sel #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .PA_W   (PA_W),
        .PTE_W  (PTE_W)
    ) u_idx (
        .va_idx_i     (s_q.va[VA_W-1:OFF_W]),
        .level_i      (s_q.level),
        .table_ppn_i  (s_q.tbl),
        .entry_addr_o (entry_addr)
    );

    ptw_pte_eval #(
        .PTE_W (PTE_W),
        .PA_W  (PA_W),
        .OFF_W (OFF_W)
    ) u_eval (
        .pte_i     (mem_rsp_data_i),
        .is_leaf_i (at_leaf),
        .write_i   (s_q.wr),
        .user_i    (s_q.usr),
        .present_o (ent_present),
        .ppn_o     (ent_ppn),
        .perm_o    (ent_perm),
        .fault_o   (ent_fault)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    s_d.va    = req_va_i;
                    s_d.wr    = req_write_i;
                    s_d.usr   = req_user_i;
                    s_d.tbl   = root_ppn_i;
                    s_d.level = LVL_W'(LEVELS - 1);
                    s_d.state = ST_RD_REQ;
                end
            end
            ST_RD_REQ: begin
                if (mem_rd_ready_i)
                    s_d.state = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (ent_fault != FLT_NONE) begin
                        s_d.fault  = ent_fault;
                        s_d.flevel = s_q.level;
                        s_d.pa     = '0;
                        s_d.perm   = '0;
                        s_d.state  = ST_RESP;
                    end else if (at_leaf) begin
                        s_d.fault  = FLT_NONE;
                        s_d.flevel = '0;
                        s_d.pa     = {ent_ppn, s_q.va[OFF_W-1:0]};
                        s_d.perm   = ent_perm;
                        s_d.state  = ST_RESP;
                    end else begin
                        s_d.tbl    = ent_ppn;
                        s_d.level  = s_q.level - 1'b1;
                        s_d.state  = ST_RD_REQ;
                    end
                end
            end
            ST_RESP: begin
                if (rsp_ready_i)
                    s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, fault: FLT_NONE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready_o    = (s_q.state == ST_IDLE);
    assign mem_rd_valid_o = (s_q.state == ST_RD_REQ);
    assign mem_rd_addr_o  = entry_addr;
    assign rsp_valid_o    = (s_q.state == ST_RESP);
    assign rsp_pa_o       = s_q.pa;
    assign rsp_perm_o     = s_q.perm;
    assign rsp_fault_o    = s_q.fault;
    assign rsp_level_o    = s_q.flevel;

endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
    parameter int unsigned LEVELS = 4,
    parameter int unsigned PA_W   = 52,
    localparam int unsigned LVL_W = $clog2(LEVELS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic             mem_rd_valid_o,
    input logic             mem_rd_ready_i,
    input logic [PA_W-1:0]  mem_rd_addr_o,
    input logic             rsp_valid_o,
    input logic             rsp_ready_i,
    input logic [PA_W-1:0]  rsp_pa_o,
    input logic [2:0]       rsp_perm_o,
    input logic [1:0]       rsp_fault_o,
    input logic [LVL_W-1:0] rsp_level_o
);

    // reads handed to memory since the last accepted request
    logic [LVL_W:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_cnt <= '0;
        else if (req_valid_i && req_ready_o)
            rd_cnt <= '0;
        else if (mem_rd_valid_o && mem_rd_ready_i)
            rd_cnt <= rd_cnt + 1'b1;
    end

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o)
            && $stable(rsp_fault_o) && $stable(rsp_level_o) && $stable(rsp_perm_o));

    // R7
    single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !rsp_valid_o && !mem_rd_valid_o);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_addr_o));

    // R2
    rd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid_o |-> (int'(rd_cnt) < LEVELS));

    // R2
    full_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_fault_o == 2'd0 |-> (int'(rd_cnt) == LEVELS) && rsp_level_o == '0);

    // R4
    absent_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_fault_o == 2'd1 |-> (int'(rd_cnt) == LEVELS - int'(rsp_level_o)));

    // R5
    perm_leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_fault_o[1] |-> rsp_level_o == '0 && (int'(rd_cnt) == LEVELS));

endmodule

bind pt_walker ptw_chk #(.LEVELS(LEVELS), .PA_W(PA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .mem_rd_valid_o (mem_rd_valid_o),
    .mem_rd_ready_i (mem_rd_ready_i),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_ready_i    (rsp_ready_i),
    .rsp_pa_o       (rsp_pa_o),
    .rsp_perm_o     (rsp_perm_o),
    .rsp_fault_o    (rsp_fault_o),
    .rsp_level_o    (rsp_level_o)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [39:0] root_ppn;
    logic        req_valid, req_ready, req_write, req_user;
    logic [47:0] req_va;
    logic        mem_rd_valid, mem_rd_ready;
    logic [51:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid, rsp_ready;
    logic [51:0] rsp_pa;
    logic [2:0]  rsp_perm;
    logic [1:0]  rsp_fault, rsp_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .root_ppn_i(root_ppn),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
        .req_write_i(req_write), .req_user_i(req_user),
        .mem_rd_valid_o(mem_rd_valid), .mem_rd_ready_i(mem_rd_ready),
        .mem_rd_addr_o(mem_rd_addr), .mem_rsp_valid_i(mem_rsp_valid),
        .mem_rsp_data_i(mem_rsp_data), .rsp_valid_o(rsp_valid),
        .rsp_ready_i(rsp_ready), .rsp_pa_o(rsp_pa), .rsp_perm_o(rsp_perm),
        .rsp_fault_o(rsp_fault), .rsp_level_o(rsp_level)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [63:0] pmem [logic [51:0]];
    logic [51:0] rd_log [$];
    logic [39:0] next_frame = 40'h0_0000_1000;

    logic [1:0]  exp_fault, exp_level;
    logic [51:0] exp_pa;
    logic [2:0]  exp_perm;
    int          exp_n;
    logic [51:0] exp_addr [4];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rd_mem(input logic [51:0] a);
        return pmem.exists(a) ? pmem[a] : 64'h0;
    endfunction

    // memory model: one-cycle latency, random accept stalls
    initial begin
        logic        hs_pend;
        logic [51:0] hs_addr;
        logic        prev_wait;
        logic [51:0] prev_addr;
        hs_pend = 0; hs_addr = '0; prev_wait = 0; prev_addr = '0;
        mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            if (prev_wait)
                check(mem_rd_valid && mem_rd_addr == prev_addr, "R9",
                      64'(mem_rd_addr), 64'(prev_addr));
            mem_rsp_valid = 0;
            if (hs_pend) begin
                mem_rsp_valid = 1;
                mem_rsp_data  = rd_mem(hs_addr);
                hs_pend       = 0;
            end
            mem_rd_ready = ($urandom_range(3) != 0);
            if (rst_n && mem_rd_valid && mem_rd_ready) begin
                hs_pend = 1;
                hs_addr = mem_rd_addr;
                rd_log.push_back(mem_rd_addr);
            end
            prev_wait = rst_n && mem_rd_valid && !mem_rd_ready;
            prev_addr = mem_rd_addr;
        end
    end

    // fl holds {user, writable, present} for level l in bits 3l+2:3l
    task automatic make_path(input logic [47:0] va, input logic [39:0] root,
                             input logic [11:0] fl, input logic [39:0] leaf);
        logic [39:0] tbl;
        tbl = root;
        for (int l = 3; l >= 0; l--) begin
            logic [8:0]  idx;
            logic [39:0] nxt;
            idx = va[12 + 9*l +: 9];
            if (l == 0) nxt = leaf;
            else begin nxt = next_frame; next_frame++; end
            pmem[{tbl, idx, 3'b000}] = {12'($urandom), nxt, 9'($urandom), fl[3*l +: 3]};
            tbl = nxt;
        end
    endtask

    task automatic ref_walk(input logic [47:0] va, input logic w, input logic u, input logic [39:0] root);
        logic [39:0] tbl;
        tbl = root;
        exp_n = 0;
        for (int l = 3; l >= 0; l--) begin
            logic [51:0] a;
            logic [63:0] e;
            a = {tbl, va[12 + 9*l +: 9], 3'b000};
            exp_addr[exp_n] = a;
            exp_n++;
            e = rd_mem(a);
            if (!e[0]) begin
                exp_fault = 2'd1; exp_level = 2'(l); exp_pa = '0; exp_perm = '0;
                return;
            end
            if (l == 0) begin
                exp_level = 2'd0;
                if (u && !e[2])      exp_fault = 2'd2;
                else if (w && !e[1]) exp_fault = 2'd3;
                else                 exp_fault = 2'd0;
                if (exp_fault == 2'd0) begin
                    exp_pa = {e[51:12], va[11:0]}; exp_perm = e[2:0];
                end else begin
                    exp_pa = '0; exp_perm = '0;
                end
                return;
            end
            tbl = e[51:12];
        end
    endtask

    task automatic do_walk(input logic [47:0] va, input logic w, input logic u, input logic [39:0] root,
                           input int hold, input bit glitch, input string req);
        logic [51:0] cap_pa;
        logic [2:0]  cap_perm;
        logic [1:0]  cap_fault, cap_level;
        bit          stab;
        int          t;
        ref_walk(va, w, u, root);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_log.delete();
        root_ppn = root; req_va = va; req_write = w; req_user = u; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        req_va    = {16'($urandom), 32'($urandom)};
        req_write = 1'($urandom);
        req_user  = 1'($urandom);
        if (glitch) root_ppn = {8'($urandom), 32'($urandom)};
        check(!req_ready, "R7", 64'(req_ready), 64'd0);
        t = 0;
        while (!rsp_valid && t < 2000) begin @(negedge clk); t++; end
        cap_pa = rsp_pa; cap_perm = rsp_perm; cap_fault = rsp_fault; cap_level = rsp_level;
        stab = 1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (!rsp_valid || req_ready || rsp_pa != cap_pa || rsp_perm != cap_perm ||
                rsp_fault != cap_fault || rsp_level != cap_level) stab = 0;
        end
        if (hold > 0) check(stab, "R7", 64'(stab), 64'd1);
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        check(!rsp_valid && req_ready, "R7", {62'd0, rsp_valid, req_ready}, 64'd1);
        check(cap_fault == exp_fault, req, 64'(cap_fault), 64'(exp_fault));
        check(cap_level == exp_level, req, 64'(cap_level), 64'(exp_level));
        check(cap_pa == exp_pa, req, 64'(cap_pa), 64'(exp_pa));
        check(cap_perm == exp_perm, req, 64'(cap_perm), 64'(exp_perm));
        check(rd_log.size() == exp_n, "R2", 64'(rd_log.size()), 64'(exp_n));
        for (int i = 0; i < exp_n && i < rd_log.size(); i++)
            check(rd_log[i] == exp_addr[i], "R2", 64'(rd_log[i]), 64'(exp_addr[i]));
    endtask

    task automatic directed(input logic [47:0] va, input logic [11:0] fl, input logic w, input logic u,
                            input int hold, input bit glitch, input string req);
        logic [39:0] root;
        root = next_frame;
        next_frame++;
        make_path(va, root, fl, {8'($urandom), 32'($urandom)});
        do_walk(va, w, u, root, hold, glitch, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        rst_n = 0; root_ppn = '0; req_valid = 0; req_va = '0;
        req_write = 0; req_user = 0; rsp_ready = 0;
        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_rd_valid, "R1",
              {61'd0, req_ready, rsp_valid, mem_rd_valid}, 64'd4);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_rd_valid, "R1",
              {61'd0, req_ready, rsp_valid, mem_rd_valid}, 64'd4);

        directed(48'hA5A5_1234_5678, 12'hFFF, 1'b0, 1'b1, 0, 1'b0, "R3");
        directed(48'hFFFF_FFFF_FFFF, 12'hFFF, 1'b1, 1'b0, 2, 1'b0, "R3");
        directed(48'h0000_0000_0000, 12'hFFF, 1'b0, 1'b0, 0, 1'b0, "R3");
        directed(48'h1357_9BDF_0246, 12'hDFF, 1'b0, 1'b1, 0, 1'b0, "R4");
        directed(48'h2468_ACE0_1357, 12'hFF7, 1'b1, 1'b0, 1, 1'b0, "R4");
        directed(48'h7FFF_0000_FFFF, 12'hFFE, 1'b0, 1'b0, 0, 1'b0, "R4");
        directed(48'h0F0F_F0F0_0F0F, 12'hFFB, 1'b0, 1'b1, 0, 1'b0, "R5");
        directed(48'h0F0F_F0F0_0F0F, 12'hFFB, 1'b0, 1'b0, 0, 1'b0, "R5");
        directed(48'h3C3C_C3C3_3C3C, 12'hFFD, 1'b1, 1'b0, 0, 1'b0, "R6");
        directed(48'h5A5A_A5A5_5A5A, 12'hFF9, 1'b1, 1'b1, 0, 1'b0, "R6");
        directed(48'h6B6B_B6B6_6B6B, 12'h24F, 1'b1, 1'b1, 0, 1'b0, "R10");
        directed(48'h7C7C_C7C7_7C7C, 12'hFFF, 1'b0, 1'b1, 0, 1'b1, "R8");
        directed(48'h8D8D_D8D8_8D8D, 12'hFFF, 1'b1, 1'b1, 5, 1'b0, "R7");

        for (int k = 0; k < 150; k++) begin
            logic [11:0] fl;
            logic [47:0] va;
            va = {16'($urandom), 32'($urandom)};
            for (int l = 0; l < 4; l++)
                fl[3*l +: 3] = {1'($urandom), 1'($urandom), ($urandom_range(15) != 0)};
            directed(va, fl, 1'($urandom), 1'($urandom), $urandom_range(3), 1'($urandom), "R3");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule